// File: doc/BRIEF.md
# Debug Console Packet Encoder

This block sits between a byte-wide console text stream and a UART's transmit and receive byte paths. It collects console characters into a line buffer. When a line ends, or the buffer fills, it sends the line to a remote debugger as a framed console-output packet. The packet carries the buffered bytes as hexadecimal text, followed by a modulo-256 checksum.

After the last checksum digit has gone out, the block normally waits for the debugger's reply on the receive path. A positive acknowledge releases the line. A break character releases the line and raises a one-cycle break request toward the rest of the system. Any other reply sends the whole packet again. A mode input turns off the wait, so that each packet goes out exactly once.

Top module: `dbg_console_packer`

## Requirements
- R1: An input byte of 0x0D is consumed (accepted by the handshake) and never stored, so it never appears in a packet.
- R2: The line buffer holds up to LINE_DEPTH bytes (default 100). A packet starts after a stored byte is 0x0A, or after a stored byte fills the buffer to LINE_DEPTH.
- R3: A packet is, in order:
  - 0x24 ('$');
  - 0x4F ('O');
  - for each buffered byte in arrival order, two uppercase ASCII hex digits, high nibble first.
- R4: After the payload come 0x23 ('#') and the checksum as two uppercase hex digits, high nibble first. The checksum is the 8-bit sum of 0x4F and every payload hex digit character; 0x24 is not included.
- R5: In acknowledge mode (ackBypass=0), a received 0x2B ('+') after the packet clears the line and returns the block to accepting input, with no further transmit.
- R6: A received 0x03 while the block awaits an acknowledge clears the line and drives breakReq high for exactly one cycle, the cycle after the byte was presented.
- R7: Any other byte received while the block awaits an acknowledge causes the identical packet to be retransmitted, starting from 0x24.
- R8: With ackBypass=1 the packet is sent once. The block returns to accepting input right after the last checksum digit is taken, and ignores received bytes.
- R9: inReady is low from the cycle after the line-ending byte is accepted until the transfer completes. txValid is never high while inReady is high.
- R10: While txValid is high and txReady is low, txValid and txData hold their values.
- R11: After reset, inReady=1, txValid=0 and breakReq=0.
- R12: Received bytes are ignored while the block is collecting input or transmitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Console byte |
| inValid | input | 1 | Console byte valid |
| inReady | output | 1 | Block can take a console byte |
| txData | output | 8 | Byte to the UART transmitter |
| txValid | output | 1 | txData valid |
| txReady | input | 1 | Transmitter takes txData |
| rxData | input | 8 | Byte from the UART receiver |
| rxValid | input | 1 | rxData valid for one cycle |
| ackBypass | input | 1 | 1: send each packet once without waiting |
| breakReq | output | 1 | One-cycle break request |

## Verification
The bench sweeps line lengths from one byte up to a full buffer. It uses byte values that touch every nibble and three transmitter stall patterns. Each packet is compared byte for byte against a packet built arithmetically in the bench.

The bench targets a specific set of corner cases, each with the fault it exposes:
- A line that fills the buffer without a newline. A design that waits only for the newline would hang here.
- A carriage return in the middle of a line. Storing it would shift every following hex pair.
- A checksum over both digits of a newline byte. A design that dropped the newline from the sum, or added the '$', would send a wrong checksum.
- A non-acknowledge reply. A design that kept the old checksum running, or resumed mid-packet, would send a different second packet.
- A break reply. A design could miss the pulse or hold it for more than one cycle.
- Receive bytes arriving outside the acknowledge wait. A design could wrongly start a retransmission or a break from them.

// File: rtl/dbgpkt_pkg.sv
package dbgpkt_pkg;

  localparam logic [7:0] CH_CR     = 8'h0D;
  localparam logic [7:0] CH_LF     = 8'h0A;
  localparam logic [7:0] CH_START  = 8'h24;
  localparam logic [7:0] CH_KIND   = 8'h4F;
  localparam logic [7:0] CH_HASH   = 8'h23;
  localparam logic [7:0] CH_ACK    = 8'h2B;
  localparam logic [7:0] CH_BREAK  = 8'h03;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // store inData at the fill position
    logic clrLine;   // empty the line buffer
    logic startPkt;  // rewind read pointer, seed checksum
    logic addSum;    // add the accepted tx byte to the checksum
    logic nextByte;  // step the read pointer
  } dpCtrl_t;

  function automatic logic [7:0] hexChar(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

endpackage

// File: rtl/dbgpkt_datapath.sv
module dbgpkt_datapath
  import dbgpkt_pkg::*;
#(
  parameter int LINE_DEPTH = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrl_t    ctrl,
  input  logic [7:0] inData,
  input  logic [7:0] txByte,
  output logic [7:0] rdByte,
  output logic [7:0] sumOut,
  output logic       lastByte,
  output logic       fillNext
);

  localparam int IDX_W = (LINE_DEPTH > 1) ? $clog2(LINE_DEPTH) : 1;
  localparam int CNT_W = $clog2(LINE_DEPTH + 1);

  logic [7:0]       lineMem [LINE_DEPTH];
  logic [CNT_W-1:0] fillCnt;
  logic [IDX_W-1:0] rdIdx;
  logic [7:0]       sumReg;

  always_ff @(posedge clk) begin
    if (ctrl.wrEn) lineMem[fillCnt[IDX_W-1:0]] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
      rdIdx   <= '0;
      sumReg  <= '0;
    end else begin
      if (ctrl.clrLine)      fillCnt <= '0;
      else if (ctrl.wrEn)    fillCnt <= fillCnt + 1'b1;
      if (ctrl.startPkt)     rdIdx <= '0;
      else if (ctrl.nextByte) rdIdx <= rdIdx + 1'b1;
      if (ctrl.startPkt)     sumReg <= CH_KIND;
      else if (ctrl.addSum)  sumReg <= sumReg + txByte;
    end
  end

  assign rdByte   = lineMem[rdIdx];
  assign sumOut   = sumReg;
  assign lastByte = (CNT_W'(rdIdx) + 1'b1) == fillCnt;
  assign fillNext = fillCnt == CNT_W'(LINE_DEPTH - 1);

  // R2: occupancy never exceeds the buffer depth
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CNT_W'(LINE_DEPTH));

  // R1: a carriage return is never written
  p_no_cr_store_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrEn |-> inData != CH_CR);

  // R3: payload reads stay inside the stored line
  p_read_in_line_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.nextByte |-> (CNT_W'(rdIdx) + 1'b1) < fillCnt);

endmodule

// File: rtl/dbgpkt_control.sv
module dbgpkt_control
  import dbgpkt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inData,
  input  logic       inValid,
  output logic       inReady,
  output logic [7:0] txData,
  output logic       txValid,
  input  logic       txReady,
  input  logic [7:0] rxData,
  input  logic       rxValid,
  input  logic       ackBypass,
  output logic       breakReq,
  input  logic [7:0] rdByte,
  input  logic [7:0] sumIn,
  input  logic       lastByte,
  input  logic       fillNext,
  output dpCtrl_t    ctrl
);

  typedef enum logic [3:0] {
    S_COLLECT, S_START, S_KIND, S_HI, S_LO, S_HASH, S_SUMHI, S_SUMLO, S_WAIT
  } state_t;

  state_t state, stateNext;
  logic   breakNext;
  logic   txAcc;

  assign inReady = (state == S_COLLECT);
  assign txValid = (state != S_COLLECT) && (state != S_WAIT);
  assign txAcc   = txValid && txReady;

  always_comb begin
    unique case (state)
      S_START: txData = CH_START;
      S_KIND:  txData = CH_KIND;
      S_HI:    txData = hexChar(rdByte[7:4]);
      S_LO:    txData = hexChar(rdByte[3:0]);
      S_HASH:  txData = CH_HASH;
      S_SUMHI: txData = hexChar(sumIn[7:4]);
      S_SUMLO: txData = hexChar(sumIn[3:0]);
      default: txData = 8'h00;
    endcase
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    breakNext = 1'b0;
    unique case (state)
      S_COLLECT: if (inValid && inData != CH_CR) begin
        ctrl.wrEn = 1'b1;
        if (inData == CH_LF || fillNext) stateNext = S_START;
      end
      S_START: if (txAcc) begin
        ctrl.startPkt = 1'b1;
        stateNext     = S_KIND;
      end
      S_KIND: if (txAcc) stateNext = S_HI;
      S_HI: if (txAcc) begin
        ctrl.addSum = 1'b1;
        stateNext   = S_LO;
      end
      S_LO: if (txAcc) begin
        ctrl.addSum = 1'b1;
        if (lastByte) stateNext = S_HASH;
        else begin
          ctrl.nextByte = 1'b1;
          stateNext     = S_HI;
        end
      end
      S_HASH:  if (txAcc) stateNext = S_SUMHI;
      S_SUMHI: if (txAcc) stateNext = S_SUMLO;
      S_SUMLO: if (txAcc) begin
        if (ackBypass) begin
          ctrl.clrLine = 1'b1;
          stateNext    = S_COLLECT;
        end else stateNext = S_WAIT;
      end
      S_WAIT: if (rxValid) begin
        if (rxData == CH_ACK) begin
          ctrl.clrLine = 1'b1;
          stateNext    = S_COLLECT;
        end else if (rxData == CH_BREAK) begin
          ctrl.clrLine = 1'b1;
          breakNext    = 1'b1;
          stateNext    = S_COLLECT;
        end else stateNext = S_START;
      end
      default: stateNext = S_COLLECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_COLLECT;
      breakReq <= 1'b0;
    end else begin
      state    <= stateNext;
      breakReq <= breakNext;
    end
  end

  // R10: an offered byte is held until taken
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData));

  // R9: never accept console input while a packet is in flight
  p_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !inReady);

  // R6: break request is a single-cycle pulse caused by a received 0x03
  p_break_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |=> !breakReq);
  p_break_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakReq) |-> $past(rxValid) && $past(rxData) == CH_BREAK);

  // R3: every packet opens with the start character
  p_pkt_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> txData == CH_START);

endmodule

// File: rtl/dbg_console_packer.sv
module dbg_console_packer
  import dbgpkt_pkg::*;
#(
  parameter int LINE_DEPTH = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inData,
  input  logic       inValid,
  output logic       inReady,
  output logic [7:0] txData,
  output logic       txValid,
  input  logic       txReady,
  input  logic [7:0] rxData,
  input  logic       rxValid,
  input  logic       ackBypass,
  output logic       breakReq
);

  dpCtrl_t    ctrl;
  logic [7:0] rdByte;
  logic [7:0] sumVal;
  logic       lastByte;
  logic       fillNext;

  dbgpkt_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .ackBypass(ackBypass),
    .breakReq(breakReq),
    .rdByte(rdByte), .sumIn(sumVal), .lastByte(lastByte), .fillNext(fillNext),
    .ctrl(ctrl)
  );

  dbgpkt_datapath #(.LINE_DEPTH(LINE_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .inData(inData), .txByte(txData),
    .rdByte(rdByte), .sumOut(sumVal), .lastByte(lastByte), .fillNext(fillNext)
  );

endmodule

// File: tb/tb_dbg_console_packer.sv
`timescale 1ns/1ps
module tb_dbg_console_packer;

  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] txData;
  logic       txValid;
  logic       txReady = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxValid = 1'b0;
  logic       ackBypass = 1'b0;
  logic       breakReq;

  always #5 clk = ~clk;

  dbg_console_packer #(.LINE_DEPTH(DEPTH)) dut (.*);

  int checks = 0;
  int errors = 0;
  int stallMode = 0;
  int stallCnt = 0;
  int capCount = 0;
  logic [7:0] capBuf [4096];
  logic [7:0] lineBuf [16];
  int lineLen = 0;
  logic [7:0] expPkt [64];
  int expLen = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // transmitter model: stall pattern, capture, hold check (R10)
  logic       holdPrev = 1'b0;
  logic [7:0] holdData = '0;
  always @(negedge clk) begin
    if (holdPrev) begin
      chk(txValid === 1'b1, "R10 valid held", int'(txValid), 1);
      chk(txData === holdData, "R10 data held", int'(txData), int'(holdData));
    end
    stallCnt++;
    case (stallMode)
      1: txReady = (stallCnt % 3) != 0;
      2: txReady = (stallCnt % 2) == 0;
      default: txReady = 1'b1;
    endcase
    #1;
    if (txValid === 1'b1 && txReady) begin
      capBuf[capCount % 4096] = txData;
      capCount++;
    end
    holdPrev = (txValid === 1'b1) && !txReady;
    holdData = txData;
  end

  function automatic logic [7:0] hx(input int n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  function automatic void buildExp();
    int s;
    expPkt[0] = 8'h24;
    expPkt[1] = 8'h4F;
    s = 79;
    for (int i = 0; i < lineLen; i++) begin
      expPkt[2 + 2*i] = hx(int'(lineBuf[i][7:4]));
      expPkt[3 + 2*i] = hx(int'(lineBuf[i][3:0]));
      s += int'(expPkt[2 + 2*i]) + int'(expPkt[3 + 2*i]);
    end
    s = s % 256;
    expPkt[2 + 2*lineLen] = 8'h23;
    expPkt[3 + 2*lineLen] = hx(s / 16);
    expPkt[4 + 2*lineLen] = hx(s % 16);
    expLen = 5 + 2*lineLen;
  endfunction

  // caller is at a negedge; returns at the negedge after acceptance
  task automatic putByte(input logic [7:0] b);
    bit ok;
    inData = b;
    inValid = 1'b1;
    forever begin
      #1 ok = inReady;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitPacket(input int base);
    int t = 0;
    while (capCount < base + expLen && t < 2000) begin
      @(negedge clk);
      #2;
      t++;
    end
  endtask

  task automatic comparePacket(input int base, input string tag);
    chk(capCount >= base + expLen, {tag, " packet length"}, capCount - base, expLen);
    for (int i = 0; i < expLen; i++)
      chk(capBuf[(base + i) % 4096] === expPkt[i], tag,
          int'(capBuf[(base + i) % 4096]), int'(expPkt[i]));
  endtask

  task automatic sendRx(input logic [7:0] b);
    rxData = b;
    rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
    #1;
  endtask

  // drive a line of len bytes; lf adds a terminating 0x0A, crAt inserts a CR
  task automatic driveLine(input int seed, input int len, input bit lf, input int crAt);
    logic [7:0] b;
    lineLen = 0;
    for (int k = 0; k < len; k++) begin
      if (k == crAt) putByte(8'h0D);
      b = 8'((seed*29 + k*53 + 7) & 255);
      if (b == 8'h0D || b == 8'h0A) b = b ^ 8'h40;
      lineBuf[lineLen] = b;
      lineLen++;
      putByte(b);
    end
    if (lf) begin
      lineBuf[lineLen] = 8'h0A;
      lineLen++;
      putByte(8'h0A);
    end
    #1;
    chk(inReady == 1'b0, "R9 inReady low after line end", int'(inReady), 0);
    buildExp();
  endtask

  int base;

  initial begin : wd
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(inReady == 1'b1, "R11 reset inReady", int'(inReady), 1);
    chk(txValid == 1'b0, "R11 reset txValid", int'(txValid), 0);
    chk(breakReq == 1'b0, "R11 reset breakReq", int'(breakReq), 0);

    // R12: stray receive bytes while collecting
    @(negedge clk);
    sendRx(8'h03);
    chk(breakReq == 1'b0, "R12 no break while collecting", int'(breakReq), 0);
    sendRx(8'h55);
    @(negedge clk);
    #1;
    chk(txValid == 1'b0, "R12 no tx from stray rx", int'(txValid), 0);
    chk(inReady == 1'b1, "R12 still collecting", int'(inReady), 1);

    // sweep of newline-terminated lines, R1 R3 R4 R5 R9
    for (int n = 0; n < DEPTH; n++) begin
      stallMode = n % 3;
      @(negedge clk);
      base = capCount;
      driveLine(n, n, 1'b1, (n > 1) ? 1 : -1);
      waitPacket(base);
      comparePacket(base, (n > 1) ? "R1 R3 R4 packet with CR dropped" : "R3 R4 packet");
      @(negedge clk);
      #1;
      chk(inReady == 1'b0, "R9 inReady low awaiting ack", int'(inReady), 0);
      chk(txValid == 1'b0, "R12 idle awaiting ack", int'(txValid), 0);
      sendRx(8'h2B);
      chk(inReady == 1'b1, "R5 accepts input after ack", int'(inReady), 1);
      chk(breakReq == 1'b0, "R5 no break on ack", int'(breakReq), 0);
      repeat (3) @(negedge clk);
      #1;
      chk(capCount == base + expLen, "R5 no transmit after ack", capCount - base, expLen);
    end

    // R2: full buffer without newline
    stallMode = 1;
    @(negedge clk);
    base = capCount;
    driveLine(40, DEPTH, 1'b0, 3);
    waitPacket(base);
    comparePacket(base, "R2 full-buffer packet");

    // R7: non-ack reply retransmits identical packet, twice
    for (int r = 0; r < 2; r++) begin
      @(negedge clk);
      base = capCount;
      sendRx(8'h78);
      waitPacket(base);
      comparePacket(base, "R7 retransmitted packet");
    end
    @(negedge clk);
    sendRx(8'h2B);
    chk(inReady == 1'b1, "R5 ack after retransmit", int'(inReady), 1);

    // R6: break reply
    stallMode = 2;
    @(negedge clk);
    base = capCount;
    driveLine(77, 3, 1'b1, -1);
    waitPacket(base);
    comparePacket(base, "R6 packet before break");
    @(negedge clk);
    sendRx(8'h03);
    chk(breakReq == 1'b1, "R6 break pulse", int'(breakReq), 1);
    chk(inReady == 1'b1, "R6 line released", int'(inReady), 1);
    @(negedge clk);
    #1;
    chk(breakReq == 1'b0, "R6 break one cycle", int'(breakReq), 0);
    chk(txValid == 1'b0, "R6 no retransmit", int'(txValid), 0);

    // R8: bypass mode
    ackBypass = 1'b1;
    stallMode = 0;
    for (int n = 1; n < 4; n++) begin
      @(negedge clk);
      base = capCount;
      driveLine(90 + n, n, 1'b1, -1);
      waitPacket(base);
      comparePacket(base, "R8 bypass packet");
      @(negedge clk);
      #1;
      chk(inReady == 1'b1, "R8 no ack wait", int'(inReady), 1);
      chk(txValid == 1'b0, "R8 sent once", int'(txValid), 0);
      sendRx(8'h41);
      chk(breakReq == 1'b0, "R8 rx ignored", int'(breakReq), 0);
      @(negedge clk);
      #1;
      chk(txValid == 1'b0, "R8 rx starts nothing", int'(txValid), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule